// File: doc/BRIEF.md
# Split/Cascade Timer-Counter with Capture

This block is a general-purpose timer/counter built from two 8-bit halves. Depending on a 2-bit operating mode the halves run as two separate timers, as a prescaled timer next to a raw event counter, or chained into a single 16-bit timer or 16-bit event counter. Timer ticks come from a shared programmable prescaler; event ticks come from rising edges of an external event input. Each half compares its count with its own match value, wraps to zero on a match and raises a sticky interrupt flag.

Two external capture inputs snapshot the running count on their rising edges into capture registers. Software programs the block through a small synchronous write/read bus. A write of the mode register restarts both counters and the prescaler. The counters only advance while the run bit is set.

Top module: `mtc_top`

## Requirements
- R1: After synchronous reset all registers read zero, the run bit is clear and both interrupt outputs are low.
- R2: The prescaler divides the clock by (PRESC + 1), so PRESC = 0 ticks every cycle; neither prescaler nor counters move while RUN (address 1, bit 0) is 0.
- R3: In mode 0 (MODE address 0, bits [1:0] = 0) both halves count prescaler ticks independently, each against its own match value (MATCH_LO address 3, MATCH_HI address 4).
- R4: In mode 1 the low half counts prescaler ticks and the high half counts rising edges of `ev_in`, each edge counted once after a two-flop synchroniser.
- R5: In mode 2 the halves form one 16-bit timer on prescaler ticks, compared with {MATCH_HI, MATCH_LO}; a 16-bit match sets only the high flag and never the low flag.
- R6: In mode 3 the halves form one 16-bit counter of `ev_in` rising edges; the prescaler setting has no effect on it.
- R7: On a tick where a count equals its match value the count reloads to zero and its flag sets; a match value of 0 holds the count at 0 and sets the flag on every tick.
- R8: Flags read at address 5 (bit 0 low, bit 1 high) and drive `irq_lo`/`irq_hi`; writing 1 to a bit clears it, writing 0 leaves it unchanged, and otherwise a set flag stays set.
- R9: In modes 0 and 1, a rising edge on `cap_lo_in` copies the low count into CAP_LO (address 8) and a rising edge on `cap_hi_in` copies the high count into CAP_HI (address 9); capture registers change at no other time.
- R10: In modes 2 and 3, a rising edge on `cap_lo_in` copies all 16 count bits into CAP_HI:CAP_LO in one cycle, and `cap_hi_in` is ignored.
- R11: Writing MODE clears both counters and the prescaler phase but leaves the flags untouched.
- R12: `rdata` is registered: it shows the register selected by `addr` one clock after `addr` is presented (CNT_LO address 6, CNT_HI address 7, PRESC address 2 read back as written).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ev_in | input | 1 | External event input for counter modes |
| cap_lo_in | input | 1 | Capture trigger for the low half or the full 16 bits |
| cap_hi_in | input | 1 | Capture trigger for the high half |
| irq_lo | output | 1 | Low-half match flag |
| irq_hi | output | 1 | High-half or 16-bit match flag |

## Verification
A miscounted prescaler phase or a lost carry between the halves shows at the ports as a count value off from the tick total computed from the number of enabled cycles, readable on the bus one cycle after selection. A wrong compare or wrap appears on `irq_lo`/`irq_hi` the cycle after the offending tick and persists, since the flags are sticky. A capture from the wrong half or at the wrong time is visible as soon as the capture registers are read after a trigger pulse, and a missed mode-write clear shows as a nonzero count read straight after the write.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  localparam int MTC_ADDR_W = 4;

  typedef enum logic [1:0] {
    MODE_SPLIT    = 2'd0,
    MODE_MIXED    = 2'd1,
    MODE_WIDE_TMR = 2'd2,
    MODE_WIDE_EVT = 2'd3
  } mtc_mode_e;

  localparam logic [MTC_ADDR_W-1:0] A_MODE   = 4'd0;
  localparam logic [MTC_ADDR_W-1:0] A_RUN    = 4'd1;
  localparam logic [MTC_ADDR_W-1:0] A_PRESC  = 4'd2;
  localparam logic [MTC_ADDR_W-1:0] A_MLO    = 4'd3;
  localparam logic [MTC_ADDR_W-1:0] A_MHI    = 4'd4;
  localparam logic [MTC_ADDR_W-1:0] A_FLAGS  = 4'd5;
  localparam logic [MTC_ADDR_W-1:0] A_CNTLO  = 4'd6;
  localparam logic [MTC_ADDR_W-1:0] A_CNTHI  = 4'd7;
  localparam logic [MTC_ADDR_W-1:0] A_CAPLO  = 4'd8;
  localparam logic [MTC_ADDR_W-1:0] A_CAPHI  = 4'd9;

  // index of each external input in the synchroniser bank
  localparam int IN_EV    = 0;
  localparam int IN_CAPLO = 1;
  localparam int IN_CAPHI = 2;
  localparam int N_INPUTS = 3;

endpackage

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);

  logic [W-1:0] phase_q;
  logic         at_end;

  assign at_end = (phase_q == div);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= at_end ? '0 : phase_q + 1'b1;
    end
  end

  assign tick = run && !clr && at_end;

endmodule

// File: rtl/mtc_rise_sync.sv
module mtc_rise_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-1:0], din};
    end
  end

  assign rise = sh_q[STAGES-1] && !sh_q[STAGES];

endmodule

// File: rtl/mtc_half_cnt.sv
module mtc_half_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic         wrap,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr || wrap) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mtc_top.sv
module mtc_top
  import mtc_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [MTC_ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0]     wdata,
  output logic [HALF_W-1:0]     rdata,
  input  logic                  ev_in,
  input  logic                  cap_lo_in,
  input  logic                  cap_hi_in,
  output logic                  irq_lo,
  output logic                  irq_hi
);

  localparam logic [HALF_W-1:0] HALF_MAX = {HALF_W{1'b1}};

  // ---------------- control registers ----------------
  mtc_mode_e          mode_q;
  logic               run_q;
  logic [PRE_W-1:0]   presc_q;
  logic [HALF_W-1:0]  mlo_q, mhi_q;
  logic               mode_wr, flags_wr;

  assign mode_wr  = wr_en && (addr == A_MODE);
  assign flags_wr = wr_en && (addr == A_FLAGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_SPLIT;
      run_q   <= 1'b0;
      presc_q <= '0;
      mlo_q   <= '0;
      mhi_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MODE:  mode_q  <= mtc_mode_e'(wdata[1:0]);
        A_RUN:   run_q   <= wdata[0];
        A_PRESC: presc_q <= wdata[PRE_W-1:0];
        A_MLO:   mlo_q   <= wdata;
        A_MHI:   mhi_q   <= wdata;
        default: ;
      endcase
    end
  end

  // ---------------- input synchronisers ----------------
  logic [N_INPUTS-1:0] raw_in, rise;
  assign raw_in = {cap_hi_in, cap_lo_in, ev_in};

  for (genvar gi = 0; gi < N_INPUTS; gi++) begin : g_sync
    mtc_rise_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[gi]),
      .rise (rise[gi])
    );
  end

  // ---------------- tick sources ----------------
  logic p_tick, e_tick;

  mtc_prescaler #(.W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (mode_wr),
    .run  (run_q),
    .div  (presc_q),
    .tick (p_tick)
  );

  assign e_tick = run_q && !mode_wr && rise[IN_EV];

  // ---------------- count steering ----------------
  logic [1:0][HALF_W-1:0] cnt_q;
  logic [1:0]             inc, wrap;
  logic                   wide, t_lo, t_hi, t_w;
  logic                   eq_lo, eq_hi, eq_w;
  logic                   set_lo, set_hi;

  assign wide  = (mode_q == MODE_WIDE_TMR) || (mode_q == MODE_WIDE_EVT);
  assign eq_lo = (cnt_q[0] == mlo_q);
  assign eq_hi = (cnt_q[1] == mhi_q);
  assign eq_w  = eq_lo && eq_hi;

  always_comb begin
    t_lo = 1'b0;
    t_hi = 1'b0;
    t_w  = 1'b0;
    case (mode_q)
      MODE_SPLIT:    begin t_lo = p_tick; t_hi = p_tick; end
      MODE_MIXED:    begin t_lo = p_tick; t_hi = e_tick; end
      MODE_WIDE_TMR: t_w = p_tick;
      MODE_WIDE_EVT: t_w = e_tick;
      default: ;
    endcase
  end

  always_comb begin
    if (wide) begin
      wrap[0] = t_w && eq_w;
      wrap[1] = t_w && eq_w;
      inc[0]  = t_w && !eq_w;
      inc[1]  = t_w && !eq_w && (cnt_q[0] == HALF_MAX);
      set_lo  = 1'b0;
      set_hi  = t_w && eq_w;
    end else begin
      wrap[0] = t_lo && eq_lo;
      wrap[1] = t_hi && eq_hi;
      inc[0]  = t_lo && !eq_lo;
      inc[1]  = t_hi && !eq_hi;
      set_lo  = wrap[0];
      set_hi  = wrap[1];
    end
  end

  for (genvar gh = 0; gh < 2; gh++) begin : g_half
    mtc_half_cnt #(.W(HALF_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (mode_wr),
      .inc  (inc[gh]),
      .wrap (wrap[gh]),
      .cnt  (cnt_q[gh])
    );
  end

  // ---------------- match flags ----------------
  logic flag_lo_q, flag_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_lo_q <= 1'b0;
      flag_hi_q <= 1'b0;
    end else begin
      if (set_lo)                     flag_lo_q <= 1'b1;
      else if (flags_wr && wdata[0])  flag_lo_q <= 1'b0;
      if (set_hi)                     flag_hi_q <= 1'b1;
      else if (flags_wr && wdata[1])  flag_hi_q <= 1'b0;
    end
  end

  assign irq_lo = flag_lo_q;
  assign irq_hi = flag_hi_q;

  // ---------------- capture ----------------
  logic [HALF_W-1:0] cap_lo_q, cap_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lo_q <= '0;
      cap_hi_q <= '0;
    end else if (wide) begin
      if (rise[IN_CAPLO]) begin
        cap_lo_q <= cnt_q[0];
        cap_hi_q <= cnt_q[1];
      end
    end else begin
      if (rise[IN_CAPLO]) cap_lo_q <= cnt_q[0];
      if (rise[IN_CAPHI]) cap_hi_q <= cnt_q[1];
    end
  end

  // ---------------- registered read port ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_MODE:  rdata <= HALF_W'(mode_q);
        A_RUN:   rdata <= HALF_W'(run_q);
        A_PRESC: rdata <= HALF_W'(presc_q);
        A_MLO:   rdata <= mlo_q;
        A_MHI:   rdata <= mhi_q;
        A_FLAGS: rdata <= HALF_W'({flag_hi_q, flag_lo_q});
        A_CNTLO: rdata <= cnt_q[0];
        A_CNTHI: rdata <= cnt_q[1];
        A_CAPLO: rdata <= cap_lo_q;
        A_CAPHI: rdata <= cap_hi_q;
        default: rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [3:0]        addr,
  input logic              wbit0,
  input logic              wbit1,
  input logic              run,
  input logic [1:0]        mode,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi,
  input logic [HALF_W-1:0] cap_lo,
  input logic [HALF_W-1:0] cap_hi,
  input logic              cap_lo_rise,
  input logic              cap_hi_rise,
  input logic              irq_lo,
  input logic              irq_hi
);

  logic mode_wr, clr_lo_wr, clr_hi_wr;
  assign mode_wr   = wr_en && (addr == 4'd0);
  assign clr_lo_wr = wr_en && (addr == 4'd5) && wbit0;
  assign clr_hi_wr = wr_en && (addr == 4'd5) && wbit1;

  assert_mode_write_clears_R11: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (cnt_lo == '0) && (cnt_hi == '0));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !mode_wr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  assert_lo_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_lo && !clr_lo_wr) |=> irq_lo);

  assert_hi_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_hi && !clr_hi_wr) |=> irq_hi);

  assert_wide_no_lo_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && !irq_lo) |=> !irq_lo);

  assert_capture_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!cap_lo_rise && !cap_hi_rise) |=> ($stable(cap_lo) && $stable(cap_hi)));

  assert_wide_ignores_hi_R10: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && !cap_lo_rise) |=> $stable(cap_hi));

endmodule

bind mtc_top mtc_checker #(.HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .addr        (addr),
  .wbit0       (wdata[0]),
  .wbit1       (wdata[1]),
  .run         (run_q),
  .mode        (mode_q),
  .cnt_lo      (cnt_q[0]),
  .cnt_hi      (cnt_q[1]),
  .cap_lo      (cap_lo_q),
  .cap_hi      (cap_hi_q),
  .cap_lo_rise (rise[1]),
  .cap_hi_rise (rise[2]),
  .irq_lo      (irq_lo),
  .irq_hi      (irq_hi)
);

// File: tb/mtc_top_tb.sv
module mtc_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ev_in = 1'b0, cap_lo_in = 1'b0, cap_hi_in = 1'b0;
  logic       irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] MODE = 0, RUN = 1, PRESC = 2, MLO = 3, MHI = 4,
                         FLAGS = 5, CNTLO = 6, CNTHI = 7, CAPLO = 8, CAPHI = 9;

  always #5 clk = ~clk;

  mtc_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_in(ev_in), .cap_lo_in(cap_lo_in),
    .cap_hi_in(cap_hi_in), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output int d);
    addr = a;
    @(negedge clk);
    d = int'(rdata);
  endtask

  task automatic rd_check(string req, string what, logic [3:0] a, int exp);
    int v;
    rd(a, v);
    check(req, what, v, exp);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    repeat (2) @(negedge clk);
    sig = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // run for n+1 enabled edges
  task automatic run_for(int n);
    wr(RUN, 8'd1);
    repeat (n) @(negedge clk);
    wr(RUN, 8'd0);
  endtask

  task automatic setup(logic [1:0] m, logic [7:0] p, logic [7:0] ml, logic [7:0] mh);
    wr(MODE, {6'd0, m});
    wr(PRESC, p);
    wr(MLO, ml);
    wr(MHI, mh);
    wr(FLAGS, 8'h03);
  endtask

  task automatic t_reset();
    rd_check("R1", "count lo", CNTLO, 0);
    rd_check("R1", "count hi", CNTHI, 0);
    rd_check("R1", "flags", FLAGS, 0);
    rd_check("R1", "capture lo", CAPLO, 0);
    rd_check("R1", "run", RUN, 0);
    check("R1", "irq pins", {irq_hi, irq_lo}, 0);
  endtask

  task automatic t_split_and_capture();
    setup(2'd0, 8'd2, 8'd4, 8'hFF);
    wr(PRESC, 8'd2);
    rd_check("R12", "presc readback", PRESC, 2);
    run_for(32);                       // 33 edges / 3 = 11 ticks
    rd_check("R3", "split lo wraps at match 4", CNTLO, 1);
    rd_check("R3", "split hi", CNTHI, 11);
    rd_check("R7", "lo flag only", FLAGS, 1);
    check("R8", "irq_lo pin", irq_lo, 1);
    repeat (6) @(negedge clk);
    rd_check("R2", "held while stopped", CNTHI, 11);
    pulse(cap_lo_in);
    rd_check("R9", "cap lo", CAPLO, 1);
    rd_check("R9", "cap hi untouched", CAPHI, 0);
    pulse(cap_hi_in);
    rd_check("R9", "cap hi", CAPHI, 11);
    rd_check("R9", "cap lo kept", CAPLO, 1);
  endtask

  task automatic t_match_zero_and_clear();
    setup(2'd0, 8'd0, 8'd0, 8'd3);
    run_for(5);                        // 6 ticks
    rd_check("R7", "match 0 holds lo at 0", CNTLO, 0);
    rd_check("R7", "hi reload after match 3", CNTHI, 2);
    rd_check("R7", "both flags", FLAGS, 3);
    wr(FLAGS, 8'h00);
    rd_check("R8", "write 0 no effect", FLAGS, 3);
    wr(FLAGS, 8'h01);
    rd_check("R8", "clear lo only", FLAGS, 2);
    wr(FLAGS, 8'h02);
    rd_check("R8", "clear hi", FLAGS, 0);
  endtask

  task automatic t_mixed();
    setup(2'd1, 8'd0, 8'hFF, 8'hFF);
    wr(RUN, 8'd1);
    pulse(ev_in); pulse(ev_in); pulse(ev_in);
    repeat (4) @(negedge clk);
    wr(RUN, 8'd0);                     // 17 enabled edges
    rd_check("R4", "mixed lo timer", CNTLO, 17);
    rd_check("R4", "mixed hi events", CNTHI, 3);
  endtask

  task automatic t_wide_timer();
    setup(2'd2, 8'd0, 8'h05, 8'h01);
    run_for(269);                      // 270 ticks, wrap at 261
    rd_check("R5", "wide lo", CNTLO, 8);
    rd_check("R5", "wide hi", CNTHI, 0);
    rd_check("R5", "only hi flag", FLAGS, 2);
    wr(MODE, 8'd2);
    rd_check("R11", "mode write clears lo", CNTLO, 0);
    rd_check("R11", "flags kept", FLAGS, 2);
  endtask

  task automatic t_wide_capture();
    setup(2'd2, 8'd0, 8'hFF, 8'hFF);
    run_for(299);                      // 300 = 0x12C
    rd_check("R5", "carry into hi", CNTHI, 1);
    rd_check("R5", "lo after carry", CNTLO, 8'h2C);
    pulse(cap_lo_in);
    rd_check("R10", "16-bit cap lo", CAPLO, 8'h2C);
    rd_check("R10", "16-bit cap hi", CAPHI, 1);
    run_for(4);                        // +5 -> 0x131
    rd_check("R2", "resumed count", CNTLO, 8'h31);
    pulse(cap_hi_in);
    rd_check("R10", "hi trigger ignored lo", CAPLO, 8'h2C);
    rd_check("R10", "hi trigger ignored hi", CAPHI, 1);
  endtask

  task automatic t_wide_events();
    setup(2'd3, 8'd5, 8'hFF, 8'hFF);
    wr(RUN, 8'd1);
    repeat (5) pulse(ev_in);
    repeat (4) @(negedge clk);
    wr(RUN, 8'd0);
    rd_check("R6", "event lo", CNTLO, 5);
    rd_check("R6", "event hi", CNTHI, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_split_and_capture();
    t_match_zero_and_clear();
    t_mixed();
    t_wide_timer();
    t_wide_capture();
    t_wide_events();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule